// File: doc/BRIEF.md
# Auto-Retransmit Packet Transmit Controller

This block sequences the transmit side of a packet radio link layer. It qualifies a chip-enable input against a minimum high time. It then takes the payload at the head of a transmit FIFO and sends it. When acknowledgement is in use, it listens for an ACK after each send and resends the payload on each timeout, up to a programmed retry limit. The radio itself is abstracted as three inputs: send finished, ACK received and ACK window expired.

A good delivery raises a sent flag and pops the FIFO. When the retry limit is used up, a max-retry flag is raised instead and the payload is left in place. A saturating lost-packet counter advances, and no further packet may start until software clears the flag. Either flag drives the interrupt output. Software clears the flags, and resets the lost counter, through a write-one-to-clear port. Between packets the controller rests in standby-I while chip-enable is low, or in standby-II while chip-enable is high and there is nothing it may send.

Top module: `arq_tx_ctrl`

## Requirements
- R1: After reset, modeOut is 0 (standby-I), both flags, irq, retxCount and lostCount are 0, and no strobe is active.
- R2: From standby-I a packet starts only when chipEn has been high for CE_MIN_CYCLES consecutive cycles and fifoEmpty is low. txStart pulses in the CE_MIN_CYCLES-th such cycle, and a shorter high pulse never starts a packet.
- R3: In the send state (modeOut 2), radioDone with autoAckEn high and noAckBit low pulses rxListen in the same cycle, and the controller enters the listen state (modeOut 3).
- R4: radioDone with autoAckEn low or noAckBit high completes the packet at once: fifoPop pulses in that cycle and dataSentFlag is set in the next.
- R5: ackRcvd in the listen state pulses fifoPop in that cycle, and dataSentFlag is set in the next cycle.
- R6: ackTimeout in the listen state, with autoRetxEn high and retxCount below maxRetry, pulses txStart without fifoPop. retxCount grows by one, and the controller returns to the send state.
- R7: ackTimeout in the listen state with retxCount equal to maxRetry, or with autoRetxEn low, pops nothing and sets maxRetryFlag. lostCount grows by one, saturating at 15.
- R8: While maxRetryFlag is set, txStart never pulses.
- R9: irq is high while either flag is set. A statWrEn write clears dataSentFlag with bit 0, maxRetryFlag with bit 1 and lostCount with bit 2. A flag set in the same cycle as its clear stays set.
- R10: A completed packet (R4, R5 or R7) leads to standby-II (modeOut 1) when chipEn is high and to standby-I when it is low. In standby-II, with chipEn high, fifoEmpty low and maxRetryFlag clear, txStart pulses at once.
- R11: In standby-II a low chipEn moves the controller to standby-I in the next cycle.
- R12: retxCount returns to 0 whenever a new payload starts from standby-I or standby-II.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chipEn | input | 1 | Chip-enable request |
| fifoEmpty | input | 1 | Transmit FIFO holds no payload |
| autoAckEn | input | 1 | Wait for acknowledgement after each send |
| autoRetxEn | input | 1 | Resend on ACK timeout |
| noAckBit | input | 1 | Current packet asks for no ACK |
| maxRetry | input | CNT_W | Retransmit limit |
| radioDone | input | 1 | Radio finished sending |
| ackRcvd | input | 1 | Valid ACK inside the window |
| ackTimeout | input | 1 | ACK window expired |
| statWrEn | input | 1 | Status clear write strobe |
| statWrData | input | 3 | Clear bits: 0 sent, 1 max-retry, 2 lost counter |
| fifoPop | output | 1 | Remove head payload |
| txStart | output | 1 | Start a send |
| rxListen | output | 1 | Switch radio to listen for ACK |
| dataSentFlag | output | 1 | Delivery succeeded flag |
| maxRetryFlag | output | 1 | Retry limit exhausted flag |
| irq | output | 1 | Interrupt, high while a flag is set |
| retxCount | output | CNT_W | Retransmits of current payload |
| lostCount | output | CNT_W | Lost packets, saturating |
| modeOut | output | 2 | 0 standby-I, 1 standby-II, 2 send, 3 listen |

## Verification
The hardest state to reach is the saturated lost counter, which takes fifteen separate retry-exhaustion events. Each event needs a qualified chip-enable start followed by a full chain of timeouts. The stimulus sweeps the retry limit, the retransmit enable and the number of timeouts before an ACK, so failures pile up as a side effect of the sweep. A few extra single-timeout failures then push the counter past its ceiling. The expected retry count, lost count and outcome of every packet are worked out arithmetically from the sweep indices.

// File: rtl/arq_pkg.sv
package arq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_HOLD   = 2'd1,
    ST_SEND   = 2'd2,
    ST_LISTEN = 2'd3
  } arqState_e;

  typedef struct packed {
    logic newPayload;
    logic retxInc;
    logic setSent;
    logic setMaxRt;
  } arqStrobe_t;

endpackage

// File: rtl/arq_datapath.sv
module arq_datapath
  import arq_pkg::*;
#(
  parameter int CNT_W         = 4,
  parameter int CE_MIN_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipEn,
  input  arqStrobe_t       stb,
  input  logic [CNT_W-1:0] maxRetry,
  input  logic             statWrEn,
  input  logic [2:0]       statWrData,
  output logic             ceQual,
  output logic [CNT_W-1:0] retxCnt,
  output logic [CNT_W-1:0] lostCnt,
  output logic             sentFlag,
  output logic             maxRtFlag
);

  localparam int CE_W = $clog2(CE_MIN_CYCLES + 1);
  localparam logic [CE_W-1:0] CE_LAST = CE_W'(CE_MIN_CYCLES - 1);
  localparam logic [CNT_W-1:0] LOST_MAX = '1;

  logic [CE_W-1:0] ceCnt;
  logic clrSent, clrMaxRt, clrLost;
  logic [CNT_W-1:0] lostBase;

  assign clrSent  = statWrEn && statWrData[0];
  assign clrMaxRt = statWrEn && statWrData[1];
  assign clrLost  = statWrEn && statWrData[2];

  // chip-enable high-time qualification
  always_ff @(posedge clk) begin
    if (!rstN) ceCnt <= '0;
    else if (!chipEn) ceCnt <= '0;
    else if (ceCnt != CE_LAST) ceCnt <= ceCnt + 1'b1;
  end

  assign ceQual = chipEn && (ceCnt == CE_LAST);

  // retransmit counter, restarted per payload
  always_ff @(posedge clk) begin
    if (!rstN) retxCnt <= '0;
    else if (stb.newPayload) retxCnt <= '0;
    else if (stb.retxInc) retxCnt <= retxCnt + 1'b1;
  end

  // lost packet counter, saturating, clear then count
  always_comb begin
    lostBase = clrLost ? '0 : lostCnt;
    if (stb.setMaxRt && lostBase != LOST_MAX) lostBase = lostBase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) lostCnt <= '0;
    else lostCnt <= lostBase;
  end

  // status flags, set beats clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sentFlag  <= 1'b0;
      maxRtFlag <= 1'b0;
    end else begin
      sentFlag  <= stb.setSent  || (sentFlag  && !clrSent);
      maxRtFlag <= stb.setMaxRt || (maxRtFlag && !clrMaxRt);
    end
  end

  p_retx_below_limit_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.retxInc |-> (retxCnt < maxRetry));

  p_lost_saturates_r7: assert property (@(posedge clk) disable iff (!rstN)
    (lostCnt == LOST_MAX && !clrLost) |=> lostCnt == LOST_MAX);

  p_maxrt_counts_loss_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setMaxRt && !clrLost && lostCnt != LOST_MAX) |=> lostCnt != $past(lostCnt));

endmodule

// File: rtl/arq_ctrl.sv
module arq_ctrl
  import arq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipEn,
  input  logic             fifoEmpty,
  input  logic             autoAckEn,
  input  logic             autoRetxEn,
  input  logic             noAckBit,
  input  logic             radioDone,
  input  logic             ackRcvd,
  input  logic             ackTimeout,
  input  logic             ceQual,
  input  logic             maxRtFlag,
  input  logic [CNT_W-1:0] retxCnt,
  input  logic [CNT_W-1:0] maxRetry,
  output arqStrobe_t       stb,
  output logic             fifoPop,
  output logic             txStart,
  output logic             rxListen,
  output logic [1:0]       modeOut
);

  arqState_e state, nextState, doneDest;
  logic retryOk;

  assign retryOk  = autoRetxEn && (retxCnt < maxRetry);
  assign doneDest = chipEn ? ST_HOLD : ST_IDLE;

  always_comb begin
    nextState = state;
    stb       = '0;
    fifoPop   = 1'b0;
    txStart   = 1'b0;
    rxListen  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (ceQual && !fifoEmpty && !maxRtFlag) begin
          txStart        = 1'b1;
          stb.newPayload = 1'b1;
          nextState      = ST_SEND;
        end
      end
      ST_HOLD: begin
        if (!chipEn) begin
          nextState = ST_IDLE;
        end else if (!fifoEmpty && !maxRtFlag) begin
          txStart        = 1'b1;
          stb.newPayload = 1'b1;
          nextState      = ST_SEND;
        end
      end
      ST_SEND: begin
        if (radioDone) begin
          if (autoAckEn && !noAckBit) begin
            rxListen  = 1'b1;
            nextState = ST_LISTEN;
          end else begin
            stb.setSent = 1'b1;
            fifoPop     = 1'b1;
            nextState   = doneDest;
          end
        end
      end
      ST_LISTEN: begin
        if (ackRcvd) begin
          stb.setSent = 1'b1;
          fifoPop     = 1'b1;
          nextState   = doneDest;
        end else if (ackTimeout) begin
          if (retryOk) begin
            txStart     = 1'b1;
            stb.retxInc = 1'b1;
            nextState   = ST_SEND;
          end else begin
            stb.setMaxRt = 1'b1;
            nextState    = doneDest;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else state <= nextState;
  end

  assign modeOut = state;

  p_no_start_blocked_r8: assert property (@(posedge clk) disable iff (!rstN)
    maxRtFlag |-> !txStart);

  p_hold_exit_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && !chipEn) |=> state == ST_IDLE);

  p_no_pop_on_fail_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LISTEN && ackTimeout && !ackRcvd) |-> !fifoPop);

endmodule

// File: rtl/arq_tx_ctrl.sv
module arq_tx_ctrl
  import arq_pkg::*;
#(
  parameter int CNT_W         = 4,
  parameter int CE_MIN_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipEn,
  input  logic             fifoEmpty,
  input  logic             autoAckEn,
  input  logic             autoRetxEn,
  input  logic             noAckBit,
  input  logic [CNT_W-1:0] maxRetry,
  input  logic             radioDone,
  input  logic             ackRcvd,
  input  logic             ackTimeout,
  input  logic             statWrEn,
  input  logic [2:0]       statWrData,
  output logic             fifoPop,
  output logic             txStart,
  output logic             rxListen,
  output logic             dataSentFlag,
  output logic             maxRetryFlag,
  output logic             irq,
  output logic [CNT_W-1:0] retxCount,
  output logic [CNT_W-1:0] lostCount,
  output logic [1:0]       modeOut
);

  arqStrobe_t stb;
  logic ceQual;

  arq_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .clk, .rstN, .chipEn, .fifoEmpty, .autoAckEn, .autoRetxEn, .noAckBit,
    .radioDone, .ackRcvd, .ackTimeout, .ceQual,
    .maxRtFlag(maxRetryFlag), .retxCnt(retxCount), .maxRetry,
    .stb, .fifoPop, .txStart, .rxListen, .modeOut
  );

  arq_datapath #(.CNT_W(CNT_W), .CE_MIN_CYCLES(CE_MIN_CYCLES)) i_datapath (
    .clk, .rstN, .chipEn, .stb, .maxRetry, .statWrEn, .statWrData,
    .ceQual, .retxCnt(retxCount), .lostCnt(lostCount),
    .sentFlag(dataSentFlag), .maxRtFlag(maxRetryFlag)
  );

  assign irq = dataSentFlag || maxRetryFlag;

  p_pop_sets_sent_r5: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |=> dataSentFlag);

  p_idle_start_needs_ce_r2: assert property (@(posedge clk) disable iff (!rstN)
    (txStart && modeOut == 2'd0) |-> (chipEn && $past(chipEn)));

endmodule

// File: tb/test_arq_tx_ctrl.sv
module test_arq_tx_ctrl;

  localparam int CNT_W  = 4;
  localparam int CE_MIN = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipEn = 0, fifoEmpty = 1, autoAckEn = 1, autoRetxEn = 1, noAckBit = 0;
  logic [CNT_W-1:0] maxRetry = '0;
  logic radioDone = 0, ackRcvd = 0, ackTimeout = 0, statWrEn = 0;
  logic [2:0] statWrData = '0;
  logic fifoPop, txStart, rxListen, dataSentFlag, maxRetryFlag, irq;
  logic [CNT_W-1:0] retxCount, lostCount;
  logic [1:0] modeOut;

  int nChecks = 0;
  int nErr = 0;
  int expLost = 0;
  bit lastFailed;

  always #4 clk = ~clk;

  arq_tx_ctrl #(.CNT_W(CNT_W), .CE_MIN_CYCLES(CE_MIN)) i_arq_tx_ctrl (
    .clk, .rstN, .chipEn, .fifoEmpty, .autoAckEn, .autoRetxEn, .noAckBit,
    .maxRetry, .radioDone, .ackRcvd, .ackTimeout, .statWrEn, .statWrData,
    .fifoPop, .txStart, .rxListen, .dataSentFlag, .maxRetryFlag, .irq,
    .retxCount, .lostCount, .modeOut
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // all tasks begin and end just after a falling edge
  task automatic startPkt();
    chipEn = 1; fifoEmpty = 0;
    for (int i = 1; i <= CE_MIN; i++) begin
      #1 chk("R2 txStart after qualified CE", txStart, (i == CE_MIN));
      @(negedge clk);
    end
    chk("R2 send state", modeOut, 2);
    chk("R12 retx cleared at new payload", retxCount, 0);
  endtask

  task automatic clearFlags();
    statWrEn = 1; statWrData = 3'b011;
    @(negedge clk);
    statWrEn = 0; statWrData = '0;
    chk("R9 sent cleared", dataSentFlag, 0);
    chk("R9 maxrt cleared", maxRetryFlag, 0);
    chk("R9 irq low", irq, 0);
    chk("R10 standby-II held", modeOut, 1);
  endtask

  task automatic dropCe();
    chipEn = 0;
    @(negedge clk);
    chk("R11 standby-I after CE low", modeOut, 0);
  endtask

  task automatic runPkt(input int maxR, input bit retxEn, input int nTo, input bit keepFifo);
    lastFailed = 0;
    for (int k = 0; k < 20; k++) begin
      radioDone = 1;
      #1 chk("R3 rxListen", rxListen, 1);
      chk("R3 no pop on send done", fifoPop, 0);
      @(negedge clk);
      radioDone = 0;
      chk("R3 listen state", modeOut, 3);
      if (k < nTo) begin
        ackTimeout = 1;
        #1;
        if (retxEn && k < maxR) begin
          chk("R6 resend strobe", txStart, 1);
          chk("R6 no pop", fifoPop, 0);
          @(negedge clk);
          ackTimeout = 0;
          chk("R6 retx count", retxCount, k + 1);
          chk("R6 back to send", modeOut, 2);
        end else begin
          chk("R7 no resend", txStart, 0);
          chk("R7 no pop", fifoPop, 0);
          @(negedge clk);
          ackTimeout = 0;
          if (expLost < 15) expLost++;
          chk("R7 maxrt flag", maxRetryFlag, 1);
          chk("R9 irq on maxrt", irq, 1);
          chk("R7 lost count", lostCount, expLost);
          chk("R7 retx kept", retxCount, maxR * retxEn);
          chk("R10 standby-II after fail", modeOut, 1);
          lastFailed = 1;
          return;
        end
      end else begin
        ackRcvd = 1;
        #1 chk("R5 pop on ack", fifoPop, 1);
        @(negedge clk);
        ackRcvd = 0;
        if (!keepFifo) fifoEmpty = 1;
        chk("R5 sent flag", dataSentFlag, 1);
        chk("R9 irq on sent", irq, 1);
        chk("R10 standby-II after success", modeOut, 1);
        return;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R1 reset state
    chk("R1 mode", modeOut, 0);
    chk("R1 sent", dataSentFlag, 0);
    chk("R1 maxrt", maxRetryFlag, 0);
    chk("R1 irq", irq, 0);
    chk("R1 retx", retxCount, 0);
    chk("R1 lost", lostCount, 0);
    chk("R1 strobes", {fifoPop, txStart, rxListen}, 0);
    @(negedge clk);

    // R2 short pulse never starts
    chipEn = 1; fifoEmpty = 0;
    for (int i = 1; i < CE_MIN; i++) begin
      #1 chk("R2 short pulse no start", txStart, 0);
      @(negedge clk);
    end
    chipEn = 0;
    #1 chk("R2 short pulse no start", txStart, 0);
    @(negedge clk);
    chk("R2 still standby-I", modeOut, 0);
    fifoEmpty = 1;

    // sweep of retry configuration and timeout count
    for (int re = 0; re <= 1; re++) begin
      for (int mr = 0; mr <= 3; mr++) begin
        for (int nt = 0; nt <= mr + 1; nt++) begin
          maxRetry = CNT_W'(mr); autoRetxEn = re[0]; autoAckEn = 1; noAckBit = 0;
          startPkt();
          runPkt(mr, re[0], nt, 0);
          if (lastFailed) begin
            for (int c = 0; c < 3; c++) begin
              #1 chk("R8 blocked while maxrt", txStart, 0);
              @(negedge clk);
              chk("R8 stays standby-II", modeOut, 1);
            end
            fifoEmpty = 1;
          end
          clearFlags();
          dropCe();
        end
      end
    end

    // extra failures to reach saturation
    for (int x = 0; x < 3; x++) begin
      maxRetry = '0; autoRetxEn = 1;
      startPkt();
      runPkt(0, 1, 1, 0);
      fifoEmpty = 1;
      clearFlags();
      dropCe();
    end
    chk("R7 lost saturated", lostCount, 15);

    // clear lost counter together with a failure: clear then count
    maxRetry = '0;
    startPkt();
    radioDone = 1; @(negedge clk); radioDone = 0;
    ackTimeout = 1; statWrEn = 1; statWrData = 3'b110;
    @(negedge clk);
    ackTimeout = 0; statWrEn = 0; statWrData = '0;
    chk("R9 maxrt set beats clear", maxRetryFlag, 1);
    chk("R9 lost cleared then counted", lostCount, 1);
    fifoEmpty = 1;
    clearFlags();
    statWrEn = 1; statWrData = 3'b100;
    @(negedge clk);
    statWrEn = 0; statWrData = '0;
    chk("R9 lost cleared", lostCount, 0);
    dropCe();

    // R4 no acknowledgement, auto-ack off, with set-wins clear
    autoAckEn = 0;
    startPkt();
    radioDone = 1; statWrEn = 1; statWrData = 3'b001;
    #1 chk("R4 pop on done", fifoPop, 1);
    chk("R4 no listen", rxListen, 0);
    @(negedge clk);
    radioDone = 0; statWrEn = 0; statWrData = '0; fifoEmpty = 1;
    chk("R9 sent set beats clear", dataSentFlag, 1);
    chk("R4 standby-II", modeOut, 1);
    clearFlags();
    dropCe();

    // R4 no-ack bit in packet
    autoAckEn = 1; noAckBit = 1;
    startPkt();
    radioDone = 1;
    #1 chk("R4 noack pop", fifoPop, 1);
    chk("R4 noack no listen", rxListen, 0);
    @(negedge clk);
    radioDone = 0; fifoEmpty = 1;
    chk("R4 noack sent", dataSentFlag, 1);
    clearFlags();
    dropCe();

    // R10 resume from standby-II and R12 retx reset on next payload
    noAckBit = 0; autoRetxEn = 1; maxRetry = 4'd2;
    startPkt();
    runPkt(2, 1, 1, 1);
    #1 chk("R10 start from standby-II", txStart, 1);
    @(negedge clk);
    chk("R10 send state", modeOut, 2);
    chk("R12 retx reset", retxCount, 0);
    fifoEmpty = 1;
    runPkt(2, 1, 0, 0);
    chk("R12 retx still 0", retxCount, 0);
    clearFlags();
    dropCe();

    // completion with CE low goes straight to standby-I
    autoAckEn = 0;
    startPkt();
    chipEn = 0; radioDone = 1;
    @(negedge clk);
    radioDone = 0; fifoEmpty = 1;
    chk("R10 standby-I when CE low", modeOut, 0);

    $display("  Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

endmodule